// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

This block is a synchronous RAM of 4096 bits with two fully independent ports. Each port has its own clock and is given a data width of 1, 2, 4, 8 or 16 bits by a parameter. The two widths may differ, so one port can work on single bits or nibbles while the other works on 16-bit words of the same storage. Both ports use the same little-endian bit mapping. A word of width W at address A covers array bits A*W up to A*W+W-1.

Each port has an enable, a write enable, an address, input data and a registered output. It also has a synchronous reset that clears only that port's output register. A write puts the new data on the port's own output (write-first). A read shows the addressed contents one edge later. When the enable is low the output holds its value. For single-port use, tie port B's enable low.

Top module: `mwram_dp`

## Requirements
- R1: A port of width W (1, 2, 4, 8 or 16) addresses 4096/W words and has a log2(4096/W)-bit address. The lowest and highest addresses reach array bits 0 and 4095.
- R2: A word of width W at address A maps to array bits A*W (least significant) through A*W+W-1, on both ports.
- R3: With enable low, a port writes nothing and ignores reset. Its output keeps its previous value.
- R4: With enable and write enable high and reset low, the input data is stored at the address. The same data appears on that port's output after the edge.
- R5: With enable high and write enable low, the output shows the addressed contents after the edge.
- R6: With enable and reset high, the output becomes zero after the edge. Reset leaves the memory unchanged, and a write in the same cycle is still stored.
- R7: Each port runs on its own clock. Data written on one port is returned by a read on the other port at any later edge of the reading port's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A output-register reset, synchronous, active high |
| addr_a | input | log2(4096/A_WIDTH) | Port A word address |
| din_a | input | A_WIDTH | Port A write data |
| dout_a | output | A_WIDTH | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B output-register reset, synchronous, active high |
| addr_b | input | log2(4096/B_WIDTH) | Port B word address |
| din_b | input | B_WIDTH | Port B write data |
| dout_b | output | B_WIDTH | Port B registered read data |

## Verification
The array is kept as two banks, one owned by each port, and a stored word is the XOR of the two banks. A corrupted bank bit therefore shows on the next read of that word from either port, one edge of the reading port's clock later. Errors in the address scaling appear when the port of one width writes nibbles and the port of the other width reads whole words. They show as a wrong word or swapped nibbles on the very first cross-port read. Mistakes in the output-register control (hold, write-first, reset priority) show on the same port one edge after the stimulus.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    localparam int unsigned MW_BITS = 4096;
    localparam int unsigned MW_IDX  = $clog2(MW_BITS);

    // What the output register loads at the next edge
    typedef enum logic [1:0] {
        OUT_HOLD,
        OUT_ZERO,
        OUT_WDATA,
        OUT_MEM
    } mw_out_e;

    function automatic int unsigned mw_addr_bits(input int unsigned w);
        return $clog2(MW_BITS / w);
    endfunction

    function automatic bit mw_width_ok(input int unsigned w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

endpackage

// File: rtl/mwram_port.sv
module mwram_port
    import mwram_pkg::*;
#(
    parameter int unsigned W = 4,
    localparam int unsigned AW = mw_addr_bits(W),
    localparam int unsigned SH = $clog2(W)
) (
    input  logic               clk,
    input  logic               en,
    input  logic               we,
    input  logic               rst,
    input  logic [AW-1:0]      addr,
    input  logic [W-1:0]       din,
    input  logic [MW_BITS-1:0] peer_bank,
    output logic [MW_BITS-1:0] own_bank,
    output logic [W-1:0]       dout
);

    generate
        if (!mw_width_ok(W)) begin : g_bad_width
            $error("mwram_port: unsupported data width");
        end
    endgenerate

    logic [MW_BITS-1:0] bank = '0;
    logic [W-1:0]       dout_q = '0;
    logic [MW_IDX-1:0]  base;
    logic [W-1:0]       peer_word;
    logic [W-1:0]       own_word;
    mw_out_e            out_sel;

    assign base      = MW_IDX'(addr) << SH;
    assign peer_word = peer_bank[base +: W];
    assign own_word  = bank[base +: W];
    assign own_bank  = bank;
    assign dout      = dout_q;

    always_comb begin
        if (!en)      out_sel = OUT_HOLD;
        else if (rst) out_sel = OUT_ZERO;
        else if (we)  out_sel = OUT_WDATA;
        else          out_sel = OUT_MEM;
    end

    // Stored word = own ^ peer; a write cancels the peer's share
    always_ff @(posedge clk) begin
        if (en && we) begin
            bank[base +: W] <= din ^ peer_word;
        end
        unique case (out_sel)
            OUT_HOLD:  dout_q <= dout_q;
            OUT_ZERO:  dout_q <= '0;
            OUT_WDATA: dout_q <= din;
            OUT_MEM:   dout_q <= own_word ^ peer_word;
        endcase
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout)); // R3

    AST_NO_WRITE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(own_bank)); // R3

    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (en && we) |=> (dout == $past(din))); // R4

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst && !en)
        (en && rst) |=> (dout == '0)); // R6

endmodule

// File: rtl/mwram_dp.sv
module mwram_dp
    import mwram_pkg::*;
#(
    parameter int unsigned A_WIDTH = 4,
    parameter int unsigned B_WIDTH = 16,
    localparam int unsigned AW_A = mw_addr_bits(A_WIDTH),
    localparam int unsigned AW_B = mw_addr_bits(B_WIDTH)
) (
    input  logic               clk_a,
    input  logic               en_a,
    input  logic               we_a,
    input  logic               rst_a,
    input  logic [AW_A-1:0]    addr_a,
    input  logic [A_WIDTH-1:0] din_a,
    output logic [A_WIDTH-1:0] dout_a,
    input  logic               clk_b,
    input  logic               en_b,
    input  logic               we_b,
    input  logic               rst_b,
    input  logic [AW_B-1:0]    addr_b,
    input  logic [B_WIDTH-1:0] din_b,
    output logic [B_WIDTH-1:0] dout_b
);

    logic [MW_BITS-1:0] bank_a;
    logic [MW_BITS-1:0] bank_b;

    mwram_port #(.W(A_WIDTH)) u_port_a (
        .clk(clk_a), .en(en_a), .we(we_a), .rst(rst_a),
        .addr(addr_a), .din(din_a),
        .peer_bank(bank_b), .own_bank(bank_a), .dout(dout_a)
    );

    mwram_port #(.W(B_WIDTH)) u_port_b (
        .clk(clk_b), .en(en_b), .we(we_b), .rst(rst_b),
        .addr(addr_b), .din(din_b),
        .peer_bank(bank_a), .own_bank(bank_b), .dout(dout_b)
    );

endmodule

// File: tb/test_mwram_dp.sv
module test_mwram_dp;

    localparam int unsigned WA = 4;
    localparam int unsigned WB = 16;
    localparam int unsigned AA = 10;
    localparam int unsigned AB = 8;
    localparam int unsigned NV = 12;

    // {port(1: B), write(1), addr(12), data(16)}
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 1'b1, 12'd0,    16'h0005},
        {1'b0, 1'b1, 12'd1,    16'h000A},
        {1'b0, 1'b1, 12'd2,    16'h0003},
        {1'b0, 1'b1, 12'd3,    16'h000C},
        {1'b1, 1'b0, 12'd0,    16'h0000},
        {1'b1, 1'b1, 12'd1,    16'h1234},
        {1'b0, 1'b0, 12'd4,    16'h0000},
        {1'b0, 1'b0, 12'd7,    16'h0000},
        {1'b1, 1'b1, 12'd255,  16'hBEEF},
        {1'b0, 1'b0, 12'd1023, 16'h0000},
        {1'b0, 1'b1, 12'd1020, 16'h0006},
        {1'b1, 1'b0, 12'd255,  16'h0000}
    };

    logic clk_a = 0, clk_b = 0;
    logic en_a = 0, we_a = 0, rst_a = 0;
    logic en_b = 0, we_b = 0, rst_b = 0;
    logic [AA-1:0] addr_a = '0;
    logic [AB-1:0] addr_b = '0;
    logic [WA-1:0] din_a = '0, dout_a;
    logic [WB-1:0] din_b = '0, dout_b;

    logic [4095:0] model = '0;
    int n_run = 0, n_fail = 0;

    always #4 clk_a = ~clk_a;
    always #6.5 clk_b = ~clk_b;

    mwram_dp #(.A_WIDTH(WA), .B_WIDTH(WB)) i_mwram_dp (
        .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .rst_a(rst_a),
        .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
        .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .rst_b(rst_b),
        .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op_a(input logic e, input logic w, input logic r,
                        input logic [AA-1:0] ad, input logic [WA-1:0] d);
        @(negedge clk_a);
        en_a = e; we_a = w; rst_a = r; addr_a = ad; din_a = d;
        @(posedge clk_a);
        @(negedge clk_a);
        en_a = 0; we_a = 0; rst_a = 0;
        if (e && w) model[ad*WA +: WA] = d;
    endtask

    task automatic op_b(input logic e, input logic w, input logic r,
                        input logic [AB-1:0] ad, input logic [WB-1:0] d);
        @(negedge clk_b);
        en_b = e; we_b = w; rst_b = r; addr_b = ad; din_b = d;
        @(posedge clk_b);
        @(negedge clk_b);
        en_b = 0; we_b = 0; rst_b = 0;
        if (e && w) model[ad*WB +: WB] = d;
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [WA-1:0] held_a;
        logic [WB-1:0] held_b;

        // Reset state
        op_a(1, 0, 1, '0, '0);
        op_b(1, 0, 1, '0, '0);
        chk("R6 reset dout_a", 16'(dout_a), 16'h0);
        chk("R6 reset dout_b", 16'(dout_b), 16'h0);

        // Table walk: mixed-width writes and cross-port reads
        for (int i = 0; i < NV; i++) begin
            logic pb, wr;
            logic [11:0] ad;
            logic [15:0] dt;
            {pb, wr, ad, dt} = VEC[i];
            if (!pb) begin
                op_a(1, wr, 0, AA'(ad), WA'(dt));
                if (wr) chk("R4 write-first A", 16'(dout_a), 16'(WA'(dt)));
                else    chk("R2 R5 R7 read A", 16'(dout_a), 16'(model[ad*WA +: WA]));
            end else begin
                op_b(1, wr, 0, AB'(ad), WB'(dt));
                if (wr) chk("R4 write-first B", dout_b, dt);
                else    chk("R2 R5 R7 read B", dout_b, model[ad*WB +: WB]);
            end
        end

        // R1: lowest and highest words of both ports
        op_a(1, 1, 0, AA'(0), 4'h9);
        op_b(1, 0, 0, AB'(0), '0);
        chk("R1 low bits via B", dout_b, model[15:0]);
        op_b(1, 0, 0, AB'(255), '0);
        chk("R1 top word B", dout_b, model[4095:4080]);

        // R3: disabled write and reset have no effect
        held_a = dout_a;
        op_a(0, 1, 0, AA'(0), 4'hF);
        chk("R3 hold dout_a", 16'(dout_a), 16'(held_a));
        op_a(0, 0, 1, AA'(0), '0);
        chk("R3 reset ignored", 16'(dout_a), 16'(held_a));
        op_a(1, 0, 0, AA'(0), '0);
        chk("R3 no write when off", 16'(dout_a), 16'h9);

        // R6: reset with write still stores; memory intact
        op_b(1, 1, 1, AB'(10), 16'hA55A);
        chk("R6 reset wins dout_b", dout_b, 16'h0);
        op_b(1, 0, 0, AB'(10), '0);
        chk("R6 write during reset", dout_b, 16'hA55A);
        held_b = dout_b;
        op_b(1, 0, 1, AB'(10), '0);
        chk("R6 reset clears B", dout_b, 16'h0);
        op_a(1, 0, 0, AA'(41), '0);
        chk("R6 R7 memory kept", 16'(dout_a), 16'(held_b[7:4]));
        op_b(1, 0, 0, AB'(10), '0);
        chk("R6 memory kept B", dout_b, model[160 +: 16]);

        report();
    end

endmodule